// File: doc/BRIEF.md
# PWM Trip Unit with Consecutive-Fault Escalation

This block sits between a PWM generator and the output pins. It forces the PWM outputs to a safe level when a protection fault is present. Each fault input can be routed to a per-cycle trip class, a latching class, or both.

A per-cycle trip forces the outputs at once. It then releases itself at a chosen cycle boundary, which can be the counter-zero strobe, the period strobe, or either one. A latching trip holds the outputs in the safe state until a clear command arrives. A pulse that the generator starts while a per-cycle trip is in force stays suppressed until the generator drops it, so no truncated pulse appears when the trip releases.

A run counter watches for PWM cycles that contain a per-cycle trip. When a programmed number of such cycles follow one another, the unit sets the latching trip. A single clean cycle returns the run counter to zero. Repeated current-limit events therefore end in a shutdown, but occasional ones do not.

Top module: `ptu_trip_unit`

## Requirements
- R1: While any fault bit that is also set in `cbc_route` is high, `pwm_out` equals `safe_lvl` in the same cycle, and `cbc_active` is 1 after the next clock edge. A fault bit whose bits in both `cbc_route` and `ost_route` are 0 has no effect on `pwm_out` or on the flags.
- R2: A fault bit set in `ost_route` forces `pwm_out` to `safe_lvl` in the same cycle and sets `ost_active` at the next edge. The outputs stay forced until `ost_clear` is high in a cycle with no routed one-shot fault. After that clear, `pwm_out` follows `pwm_in` again. A routed one-shot fault wins over a clear given in the same cycle.
- R3: `clr_mode` selects when `cbc_active` releases: bit 0 = at `zero_stb`, bit 1 = at `period_stb`, 2'b11 = at either strobe, and 2'b00 behaves as 2'b01. The release takes effect at the clock edge of an enabled strobe, and only if no routed per-cycle fault is high in that cycle. A strobe that is not enabled leaves `cbc_active` set.
- R4: A fault bit set in both route masks sets both `cbc_active` and `ost_active`.
- R5: For each channel, a rising edge of `pwm_in` that occurs while a per-cycle trip is in force keeps that channel at its safe level after the trip releases, until `pwm_in` goes low. A pulse that was already high before the trip passes again once the trip releases.
- R6: A PWM cycle counts as tripped if a routed per-cycle fault was high in any clock cycle since the previous `zero_stb`, including the `zero_stb` cycle itself. At each `zero_stb`, a tripped cycle increments the run count. When the count reaches a nonzero `esc_limit`, `ost_active` is set at that same edge. With `esc_limit` = 1, a single tripped cycle escalates.
- R7: A `zero_stb` that ends a cycle with no per-cycle trip resets the run count to zero.
- R8: With `esc_limit` = 0, no number of tripped cycles sets `ost_active`.
- R9: `ost_clear` also resets the run count and the tripped-cycle record.
- R10: After reset, `cbc_active` and `ost_active` are 0 and `pwm_out` follows `pwm_in`. When no trip is in force, `pwm_out` is never high on a channel where `pwm_in` is low.
- R11: The forced level is set per channel by the matching bit of `safe_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | N_CH | PWM from the generator |
| fault_in | input | N_FLT | Fault lines, active high |
| zero_stb | input | 1 | One-cycle strobe at counter zero |
| period_stb | input | 1 | One-cycle strobe at period match |
| cbc_route | input | N_FLT | Routes each fault to the per-cycle class |
| ost_route | input | N_FLT | Routes each fault to the latching class |
| clr_mode | input | 2 | Per-cycle release boundary select |
| safe_lvl | input | N_CH | Forced level for each channel |
| esc_limit | input | LIMIT_W | Tripped-cycle run length that latches, 0 = off |
| ost_clear | input | 1 | Clears the latching trip and the run count |
| pwm_out | output | N_CH | Gated PWM to the pins |
| cbc_active | output | 1 | Per-cycle trip in force |
| ost_active | output | 1 | Latching trip in force |

## Verification
The release logic is tested with trips ended by zero strobes, by period strobes, and by a fault still held across the boundary. These cases separate correct decoding of each release mode from a trip that either releases early or holds too long. Escalation is tested with unbroken runs of tripped cycles, runs broken by one clean cycle, runs broken by a clear command, and a limit of zero. These cases separate a counter that resets on clean cycles from one that only accumulates, and they check that the threshold comparison is exact. A pulse that rises during a trip is contrasted with a pulse that was high before the trip. This shows that only new edges are held off.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

    typedef enum logic [1:0] {
        REL_DEFAULT = 2'b00,
        REL_ZERO    = 2'b01,
        REL_PERIOD  = 2'b10,
        REL_EITHER  = 2'b11
    } rel_mode_e;

    typedef struct packed {
        logic cbc;
        logic ost;
    } trip_st_t;

    typedef struct packed {
        logic prev;
        logic blk;
    } gate_st_t;

endpackage

// File: rtl/ptu_fault_route.sv
module ptu_fault_route #(
    parameter int N_FLT = 4
) (
    input  logic [N_FLT-1:0] fault_in,
    input  logic [N_FLT-1:0] cbc_route,
    input  logic [N_FLT-1:0] ost_route,
    output logic             cbc_hit,
    output logic             ost_hit
);
    logic [N_FLT-1:0] cbc_vec;
    logic [N_FLT-1:0] ost_vec;

    for (genvar g = 0; g < N_FLT; g++) begin : g_src
        assign cbc_vec[g] = fault_in[g] & cbc_route[g];
        assign ost_vec[g] = fault_in[g] & ost_route[g];
    end

    assign cbc_hit = |cbc_vec;
    assign ost_hit = |ost_vec;
endmodule

// File: rtl/ptu_run_counter.sv
module ptu_run_counter #(
    parameter int LIMIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zero_stb,
    input  logic               cbc_hit,
    input  logic               ost_clear,
    input  logic [LIMIT_W-1:0] limit,
    output logic               escalate
);
    localparam logic [LIMIT_W-1:0] CNT_MAX = {LIMIT_W{1'b1}};
    localparam logic [LIMIT_W-1:0] CNT_ONE = {{(LIMIT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic               seen;
        logic [LIMIT_W-1:0] cnt;
    } run_st_t;

    run_st_t st_d, st_q;
    logic    trip_cyc;

    always_comb begin
        st_d     = st_q;
        escalate = 1'b0;
        trip_cyc = st_q.seen | cbc_hit;
        if (ost_clear) begin
            st_d = '0;
        end else if (zero_stb) begin
            st_d.seen = 1'b0;
            if (trip_cyc) begin
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
                if ((limit != '0) && (st_d.cnt >= limit)) begin
                    escalate = 1'b1;
                    st_d.cnt = '0;
                end
            end else begin
                st_d.cnt = '0;
            end
        end else if (cbc_hit) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptu_out_gate.sv
module ptu_out_gate
    import ptu_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pwm_in,
    input  logic [N_CH-1:0] safe_lvl,
    input  logic            cbc_force,
    input  logic            ost_force,
    output logic [N_CH-1:0] pwm_out
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        gate_st_t st_d, st_q;
        logic     rise;
        logic     forced;

        always_comb begin
            rise        = pwm_in[c] & ~st_q.prev;
            st_d.prev   = pwm_in[c];
            st_d.blk    = pwm_in[c] & (st_q.blk | (rise & cbc_force));
            forced      = cbc_force | ost_force | (st_q.blk & pwm_in[c]);
            pwm_out[c]  = forced ? safe_lvl[c] : pwm_in[c];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end
endmodule

// File: rtl/ptu_trip_unit.sv
module ptu_trip_unit
    import ptu_pkg::*;
#(
    parameter int N_CH    = 2,
    parameter int N_FLT   = 4,
    parameter int LIMIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    pwm_in,
    input  logic [N_FLT-1:0]   fault_in,
    input  logic               zero_stb,
    input  logic               period_stb,
    input  logic [N_FLT-1:0]   cbc_route,
    input  logic [N_FLT-1:0]   ost_route,
    input  logic [1:0]         clr_mode,
    input  logic [N_CH-1:0]    safe_lvl,
    input  logic [LIMIT_W-1:0] esc_limit,
    input  logic               ost_clear,
    output logic [N_CH-1:0]    pwm_out,
    output logic               cbc_active,
    output logic               ost_active
);
    logic     cbc_hit, ost_hit, escalate, boundary;
    trip_st_t st_d, st_q;

    ptu_fault_route #(.N_FLT(N_FLT)) u_route (
        .fault_in  (fault_in),
        .cbc_route (cbc_route),
        .ost_route (ost_route),
        .cbc_hit   (cbc_hit),
        .ost_hit   (ost_hit)
    );

    ptu_run_counter #(.LIMIT_W(LIMIT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_stb  (zero_stb),
        .cbc_hit   (cbc_hit),
        .ost_clear (ost_clear),
        .limit     (esc_limit),
        .escalate  (escalate)
    );

    always_comb begin
        case (rel_mode_e'(clr_mode))
            REL_PERIOD: boundary = period_stb;
            REL_EITHER: boundary = period_stb | zero_stb;
            default:    boundary = zero_stb;
        endcase
        st_d.cbc = cbc_hit | (st_q.cbc & ~boundary);
        st_d.ost = ost_hit | escalate | (st_q.ost & ~ost_clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ptu_out_gate #(.N_CH(N_CH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .safe_lvl  (safe_lvl),
        .cbc_force (cbc_hit | st_q.cbc),
        .ost_force (ost_hit | st_q.ost),
        .pwm_out   (pwm_out)
    );

    assign cbc_active = st_q.cbc;
    assign ost_active = st_q.ost;
endmodule

// File: rtl/ptu_trip_unit_chk.sv
module ptu_trip_unit_chk #(
    parameter int N_CH    = 2,
    parameter int N_FLT   = 4,
    parameter int LIMIT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CH-1:0]    pwm_in,
    input logic [N_FLT-1:0]   fault_in,
    input logic               zero_stb,
    input logic               period_stb,
    input logic [N_FLT-1:0]   cbc_route,
    input logic [N_FLT-1:0]   ost_route,
    input logic [1:0]         clr_mode,
    input logic [N_CH-1:0]    safe_lvl,
    input logic [LIMIT_W-1:0] esc_limit,
    input logic               ost_clear,
    input logic [N_CH-1:0]    pwm_out,
    input logic               cbc_active,
    input logic               ost_active
);
    logic c_flt, o_flt, rel;
    assign c_flt = |(fault_in & cbc_route);
    assign o_flt = |(fault_in & ost_route);
    assign rel   = (clr_mode[1] & period_stb) | ((clr_mode[0] | ~clr_mode[1]) & zero_stb);

    p_cbc_force_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_flt |-> pwm_out == safe_lvl);
    p_cbc_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_flt |=> cbc_active);
    p_ost_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ost_active && !ost_clear |=> ost_active);
    p_ost_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ost_active |-> pwm_out == safe_lvl);
    p_cbc_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_active && !c_flt && rel |=> !cbc_active);
    p_cbc_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_active && !zero_stb && !period_stb |=> cbc_active);
    p_cbc_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cbc_active |-> pwm_out == safe_lvl);
    p_no_escalate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        esc_limit == '0 && !ost_active && !o_flt |=> !ost_active);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ost_clear && !o_flt |=> !ost_active);
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cbc_active && !ost_active && !c_flt && !o_flt |-> (pwm_out & ~pwm_in) == '0);
endmodule

bind ptu_trip_unit ptu_trip_unit_chk #(
    .N_CH(N_CH), .N_FLT(N_FLT), .LIMIT_W(LIMIT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_in(fault_in),
    .zero_stb(zero_stb), .period_stb(period_stb), .cbc_route(cbc_route),
    .ost_route(ost_route), .clr_mode(clr_mode), .safe_lvl(safe_lvl),
    .esc_limit(esc_limit), .ost_clear(ost_clear), .pwm_out(pwm_out),
    .cbc_active(cbc_active), .ost_active(ost_active)
);

// File: tb/tb_ptu_trip_unit.sv
module tb_ptu_trip_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_in = '0;
    logic [3:0] fault_in = '0;
    logic       zero_stb = 1'b0, period_stb = 1'b0;
    logic [3:0] cbc_route = '0, ost_route = '0;
    logic [1:0] clr_mode = 2'b01;
    logic [1:0] safe_lvl = 2'b10;
    logic [3:0] esc_limit = '0;
    logic       ost_clear = 1'b0;
    logic [1:0] pwm_out;
    logic       cbc_active, ost_active;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    ptu_trip_unit dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_in(fault_in),
        .zero_stb(zero_stb), .period_stb(period_stb), .cbc_route(cbc_route),
        .ost_route(ost_route), .clr_mode(clr_mode), .safe_lvl(safe_lvl),
        .esc_limit(esc_limit), .ost_clear(ost_clear), .pwm_out(pwm_out),
        .cbc_active(cbc_active), .ost_active(ost_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clear_all();
        fault_in = '0; ost_clear = 1'b1; tick(); ost_clear = 1'b0;
        zero_stb = 1'b1; tick(); zero_stb = 1'b0;
    endtask

    task automatic run_cycle(input bit with_fault);
        if (with_fault) begin fault_in = 4'b0001; tick(); fault_in = '0; end
        tick(); tick();
        zero_stb = 1'b1; tick(); zero_stb = 1'b0;
    endtask

    task automatic t_reset();
        pwm_in = 2'b01; settle();
        chk("R10 out after reset", pwm_out, 2'b01);
        chk("R10 cbc flag after reset", cbc_active, 0);
        chk("R10 ost flag after reset", ost_active, 0);
    endtask

    task automatic t_cbc_basic();
        cbc_route = 4'b0001; ost_route = 4'b0100; clr_mode = 2'b01; esc_limit = 0;
        pwm_in = 2'b11;
        fault_in = 4'b0010; settle();
        chk("R1 unrouted fault out", pwm_out, 2'b11);
        tick();
        chk("R1 unrouted fault flag", cbc_active, 0);
        fault_in = 4'b0001; settle();
        chk("R1 R11 forced same cycle", pwm_out, 2'b10);
        tick(); fault_in = '0; settle();
        chk("R1 cbc flag set", cbc_active, 1);
        chk("R11 held safe", pwm_out, 2'b10);
        period_stb = 1'b1; tick(); period_stb = 1'b0;
        chk("R3 period ignored in zero mode", cbc_active, 1);
        fault_in = 4'b0001; zero_stb = 1'b1; tick(); zero_stb = 1'b0; fault_in = '0;
        chk("R3 fault at boundary keeps trip", cbc_active, 1);
        zero_stb = 1'b1; tick(); zero_stb = 1'b0;
        chk("R3 released at zero", cbc_active, 0);
        chk("R5 older pulse passes", pwm_out, 2'b11);
    endtask

    task automatic t_clear_modes();
        clr_mode = 2'b10;
        fault_in = 4'b0001; tick(); fault_in = '0;
        zero_stb = 1'b1; tick(); zero_stb = 1'b0;
        chk("R3 zero ignored in period mode", cbc_active, 1);
        period_stb = 1'b1; tick(); period_stb = 1'b0;
        chk("R3 released at period", cbc_active, 0);
        clr_mode = 2'b00;
        fault_in = 4'b0001; tick(); fault_in = '0;
        zero_stb = 1'b1; tick(); zero_stb = 1'b0;
        chk("R3 mode 00 releases at zero", cbc_active, 0);
        clr_mode = 2'b11;
        fault_in = 4'b0001; tick(); fault_in = '0;
        period_stb = 1'b1; tick(); period_stb = 1'b0;
        chk("R3 either mode releases at period", cbc_active, 0);
        clr_mode = 2'b01;
    endtask

    task automatic t_one_shot();
        esc_limit = 0;
        fault_in = 4'b0100; settle();
        chk("R2 forced same cycle", pwm_out, 2'b10);
        tick(); fault_in = '0;
        chk("R2 ost flag set", ost_active, 1);
        zero_stb = 1'b1; period_stb = 1'b1; tick(); zero_stb = 1'b0; period_stb = 1'b0;
        tick();
        chk("R2 held over boundaries", ost_active, 1);
        chk("R2 out held safe", pwm_out, 2'b10);
        fault_in = 4'b0100; ost_clear = 1'b1; tick(); fault_in = '0; ost_clear = 1'b0;
        chk("R2 fault beats clear", ost_active, 1);
        ost_clear = 1'b1; tick(); ost_clear = 1'b0; settle();
        chk("R2 cleared", ost_active, 0);
        chk("R2 out follows after clear", pwm_out, 2'b11);
        cbc_route = 4'b1001; ost_route = 4'b1100;
        fault_in = 4'b1000; tick(); fault_in = '0;
        chk("R4 both classes cbc", cbc_active, 1);
        chk("R4 both classes ost", ost_active, 1);
        cbc_route = 4'b0001; ost_route = 4'b0100;
        clear_all();
    endtask

    task automatic t_block();
        clr_mode = 2'b01; esc_limit = 0; pwm_in = 2'b00; tick();
        fault_in = 4'b0001; tick(); fault_in = '0;
        pwm_in = 2'b11; tick();
        zero_stb = 1'b1; tick(); zero_stb = 1'b0; settle();
        chk("R5 trip released", cbc_active, 0);
        chk("R5 new edge blocked", pwm_out, 2'b10);
        pwm_in = 2'b00; settle();
        chk("R5 low passes", pwm_out, 2'b00);
        tick(); pwm_in = 2'b11; settle();
        chk("R5 next edge passes", pwm_out, 2'b11);
    endtask

    task automatic t_escalate();
        esc_limit = 3; clear_all();
        run_cycle(1); run_cycle(1);
        chk("R6 no latch after two", ost_active, 0);
        run_cycle(1);
        chk("R6 latch after three", ost_active, 1);
        esc_limit = 1; clear_all();
        run_cycle(1);
        chk("R6 limit one latches", ost_active, 1);
    endtask

    task automatic t_clean_reset();
        esc_limit = 3; clear_all();
        run_cycle(1); run_cycle(1); run_cycle(0);
        run_cycle(1); run_cycle(1);
        chk("R7 clean cycle restarts run", ost_active, 0);
        run_cycle(1);
        chk("R7 third after restart latches", ost_active, 1);
    endtask

    task automatic t_disable();
        esc_limit = 0; clear_all();
        for (int k = 0; k < 18; k++) run_cycle(1);
        chk("R8 limit zero never latches", ost_active, 0);
    endtask

    task automatic t_clear_count();
        esc_limit = 3; clear_all();
        run_cycle(1); run_cycle(1);
        ost_clear = 1'b1; tick(); ost_clear = 1'b0;
        run_cycle(1); run_cycle(1);
        chk("R9 clear restarts run", ost_active, 0);
        run_cycle(1);
        chk("R9 third after clear latches", ost_active, 1);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cbc_basic();
        t_clear_modes();
        t_one_shot();
        t_block();
        t_escalate();
        t_clean_reset();
        t_disable();
        t_clear_count();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule